// File: doc/BRIEF.md
# Burst-Aligned Multi-Channel Edge Divider

This block derives several slow synchronisation outputs from an external signal toggling in the kilohertz range. The external signal is not used as a clock. It is brought into a faster system clock domain through a two-flop synchronizer, and each rising edge found there becomes a one-cycle event. Every output channel counts these events against its own programmable half-period. The channel output toggles each time its count expires, so each output frequency tracks the incoming frequency.

When the input starts toggling after an idle spell, the first detected edge sets every enabled channel high in the same system clock cycle, which aligns all outputs to the burst onset. The block watches for inactivity with a system-clock counter that is cleared on every detected edge. When that counter reaches the programmed timeout, the burst is over: all channel counters return to their reload state, all outputs go low, and the active flag drops. The next burst then starts aligned again.

Top module: `burst_sync_divider`

## Requirements
- R1: After reset, `sync_out` is all zeros and `active` is low.
- R2: The first input rising edge seen while `active` is low sets `active`. It also drives high, in the same cycle, every channel whose half-period field is 2 or more. Both take effect on the third rising system clock edge after `sig_in` rises, counting the edge that first samples it.
- R3: A channel with half-period N (N of 2 or more) stays high for the first N input rising edges of a burst. It then toggles on every Nth input rising edge after that, so at burst edge e (counting from 1) its level is high exactly when ((e-1)/N) is even.
- R4: Outputs change only in response to detected input rising edges, so an output's frequency follows the input frequency regardless of the spacing between input edges.
- R5: A channel whose half-period field is 0 or 1 keeps its output low for the whole burst and does not take part in the start alignment.
- R6: A new half-period written during a burst is taken only at that channel's next toggle (reload). The toggle in progress still uses the old value.
- R7: With `timeout` = T (T of 1 or more), `active` stays high while T-1 system clock cycles pass without a detected edge. It falls on the next cycle if there is still no edge, and at that point every output is low. With input edges exactly T cycles apart, `active` stays high.
- R8: `sync_out` is all zeros in every cycle in which `active` is low.
- R9: `div_ratio` holds channel i in bits [i*DIV_W +: DIV_W], channel 0 in the least significant field, and `sync_out[i]` is channel i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the external signal |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Raw external signal, asynchronous to clk |
| div_ratio | input | NCH*DIV_W | Packed half-periods in input edges, one field per channel |
| timeout | input | TMO_W | Idle limit in system clock cycles |
| sync_out | output | NCH | Divided, burst-aligned outputs |
| active | output | 1 | High while a burst is in progress |

## Verification
On every cycle the assertions check several properties. Outputs are zero whenever the burst flag is low. An output moves during a burst only after a detected input edge. At burst onset exactly the channels with a valid half-period rise together. The idle span never reaches the timeout while the flag is high, and the flag falls on the cycle after the idle span reaches it. The bench scenarios cover the rest. They show the toggle sequence against a computed edge count for different ratios and input spacings. They also show a ratio change landing at the next reload, the exact cycle at which the timeout fires, and a fresh alignment on the following burst.

// File: rtl/burst_div_pkg.sv
// Package: burst_div_pkg
// Shared default sizes for the burst-aligned edge divider. Holds no logic.
package burst_div_pkg;
    localparam int DEF_NCH   = 4;
    localparam int DEF_DIV_W = 8;
    localparam int DEF_TMO_W = 16;
    localparam int MIN_HALF  = 2;
endpackage

// File: rtl/bsd_edge_sync.sv
// Module: bsd_edge_sync
// Brings an asynchronous level into the clk domain with two flops, then
// flags a rising edge as a one-cycle pulse. Assumes the input stays high
// and low for at least two clk periods each.
module bsd_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [2:0] stage;

    // Shift the raw level through the synchronizer and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[1:0], din};
    end

    // Rising edge: synchronized level high now, low one cycle earlier.
    always_comb rise = stage[1] & ~stage[2];
endmodule

// File: rtl/bsd_activity.sv
// Module: bsd_activity
// Tracks whether a burst is running. Any edge clears the idle counter. When
// the counter reaches the timeout with no edge, a one-cycle expire is raised
// and active drops in the same edge. The first edge while idle is a start.
// An edge during a burst is a step.
module bsd_activity #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic [TMO_W-1:0] timeout,
    output logic             active,
    output logic             start,
    output logic             step,
    output logic             expire
);
    logic [TMO_W:0] idle_cnt;
    logic [TMO_W:0] idle_nxt;

    // Decode burst events from the edge pulse and the idle span.
    always_comb begin
        idle_nxt = idle_cnt + 1'b1;
        start    = rise & ~active;
        step     = rise & active;
        expire   = active & ~rise & (idle_nxt >= {1'b0, timeout});
    end

    // Update the burst flag and the idle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            idle_cnt <= '0;
        end else if (rise) begin
            active   <= 1'b1;
            idle_cnt <= '0;
        end else if (expire || !active) begin
            active   <= 1'b0;
            idle_cnt <= '0;
        end else begin
            idle_cnt <= idle_nxt;
        end
    end
endmodule

// File: rtl/bsd_channel.sv
// Module: bsd_channel
// One divided output. Counts step events down from the half-period and
// toggles on expiry, reloading the half-period present at that moment.
// A half-period below MIN_HALF disables the channel and holds it low.
// Expire clears the channel to its reload state.
module bsd_channel
    import burst_div_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    input  logic             expire,
    input  logic [DIV_W-1:0] half,
    output logic             q
);
    localparam logic [DIV_W-1:0] LIMIT = DIV_W'(MIN_HALF);
    localparam logic [DIV_W-1:0] LAST  = DIV_W'(1);

    logic [DIV_W-1:0] remain;
    logic             enabled;
    logic             half_ok;

    // A usable half-period needs at least MIN_HALF edges.
    always_comb half_ok = (half >= LIMIT);

    // Channel sequencing: clear, align on start, count and toggle on steps.
    always_ff @(posedge clk) begin
        if (!rst_n || expire) begin
            remain  <= '0;
            enabled <= 1'b0;
            q       <= 1'b0;
        end else if (start) begin
            remain  <= half;
            enabled <= half_ok;
            q       <= half_ok;
        end else if (step && enabled) begin
            if (remain == LAST) begin
                if (half_ok) begin
                    remain <= half;
                    q      <= ~q;
                end else begin
                    remain  <= '0;
                    enabled <= 1'b0;
                    q       <= 1'b0;
                end
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end
endmodule

// File: rtl/burst_sync_divider.sv
// Module: burst_sync_divider
// Top of the burst-aligned multi-channel edge divider. One synchronizer and
// one activity monitor feed NCH identical divider channels. Assumes clk is
// at least four times the external signal frequency.
module burst_sync_divider
    import burst_div_pkg::*;
#(
    parameter int NCH   = DEF_NCH,
    parameter int DIV_W = DEF_DIV_W,
    parameter int TMO_W = DEF_TMO_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sig_in,
    input  logic [NCH*DIV_W-1:0] div_ratio,
    input  logic [TMO_W-1:0]     timeout,
    output logic [NCH-1:0]       sync_out,
    output logic                 active
);
    logic edge_rise;
    logic burst_start;
    logic burst_step;
    logic burst_expire;

    bsd_edge_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sig_in),
        .rise  (edge_rise)
    );

    bsd_activity #(.TMO_W(TMO_W)) u_act (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (edge_rise),
        .timeout (timeout),
        .active  (active),
        .start   (burst_start),
        .step    (burst_step),
        .expire  (burst_expire)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        bsd_channel #(.DIV_W(DIV_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (burst_start),
            .step   (burst_step),
            .expire (burst_expire),
            .half   (div_ratio[i*DIV_W +: DIV_W]),
            .q      (sync_out[i])
        );
    end
endmodule

// File: rtl/burst_sync_divider_chk.sv
// Module: burst_sync_divider_chk
// Assertion checker bound to burst_sync_divider. Keeps its own idle span
// counter to check the timeout window.
module burst_sync_divider_chk #(
    parameter int NCH   = 4,
    parameter int DIV_W = 8,
    parameter int TMO_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sig_rise,
    input logic                 active,
    input logic [NCH-1:0]       sync_out,
    input logic [NCH*DIV_W-1:0] div_ratio,
    input logic [TMO_W-1:0]     timeout
);
    logic [TMO_W:0] gap;
    logic [NCH-1:0] valid_mask;

    // Count clk cycles since the last detected edge within a burst.
    always_ff @(posedge clk) begin
        if (!rst_n || sig_rise || !active) gap <= '0;
        else                               gap <= gap + 1'b1;
    end

    // Channels whose half-period field allows them to run.
    always_comb begin
        for (int i = 0; i < NCH; i++)
            valid_mask[i] = (div_ratio[i*DIV_W +: DIV_W] >= DIV_W'(2));
    end

    // R8
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (sync_out == '0));

    // R4
    edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && !$stable(sync_out)) |-> $past(sig_rise));

    // R2
    start_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> (sync_out == $past(valid_mask)));

    // R7
    gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && timeout != '0) |-> (gap < {1'b0, timeout}));

    // R7
    expire_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !sig_rise && (gap + 1'b1) >= {1'b0, timeout}) |=> !active);
endmodule

bind burst_sync_divider burst_sync_divider_chk #(
    .NCH(NCH), .DIV_W(DIV_W), .TMO_W(TMO_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sig_rise  (edge_rise),
    .active    (active),
    .sync_out  (sync_out),
    .div_ratio (div_ratio),
    .timeout   (timeout)
);

// File: tb/burst_sync_divider_bench.sv
// Bench for burst_sync_divider: a table of bursts walked by one loop,
// then directed tests for reset, ratio change and the timeout boundary.
module burst_sync_divider_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 4;
    localparam int DIV_W = 8;
    localparam int TMO_W = 16;
    localparam int NBURST = 4;

    // Per burst: half-periods for ch0..ch3, edge count, low cycles, timeout.
    localparam int RT   [NBURST][NCH] = '{'{2, 3, 4, 5}, '{1, 0, 2, 7},
                                          '{6, 2, 3, 1}, '{2, 2, 9, 4}};
    localparam int EDGES[NBURST] = '{12, 16, 14, 20};
    localparam int LOWC [NBURST] = '{4, 10, 6, 4};
    localparam int TMOV [NBURST] = '{20, 25, 12, 9};

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sig_in = 1'b0;
    logic [NCH*DIV_W-1:0] div_ratio = '0;
    logic [TMO_W-1:0]     timeout = '0;
    logic [NCH-1:0]       sync_out;
    logic                 active;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    burst_sync_divider #(.NCH(NCH), .DIV_W(DIV_W), .TMO_W(TMO_W)) u_burst_sync_divider (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .div_ratio(div_ratio),
        .timeout(timeout), .sync_out(sync_out), .active(active)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: counts clk cycles and ends a hung run as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired got %0d expected %0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    // Level expected at burst edge e for half-period n (R3, R5).
    function automatic logic exp_level(input int n, input int e);
        if (n < 2) return 1'b0;
        return (((e - 1) / n) % 2) == 0;
    endfunction

    function automatic int exp_vec(input int r0, input int r1, input int r2,
                                   input int r3, input int e);
        return {28'd0, exp_level(r3, e), exp_level(r2, e),
                exp_level(r1, e), exp_level(r0, e)};
    endfunction

    task automatic set_ratios(input int r0, input int r1, input int r2, input int r3);
        div_ratio = {DIV_W'(r3), DIV_W'(r2), DIV_W'(r1), DIV_W'(r0)};
    endtask

    // Called at a negedge: raise sig_in, return three clk cycles later at a negedge.
    task automatic in_rise();
        sig_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    // Finish the high phase (four cycles total) and hold low for lowc cycles.
    task automatic in_low(input int lowc);
        @(negedge clk);
        sig_in = 1'b0;
        repeat (lowc) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1 sync_out", sync_out, 0);
        check("R1 active", active, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {active, sync_out}, 0);

        // Table of bursts.
        for (int b = 0; b < NBURST; b++) begin
            set_ratios(RT[b][0], RT[b][1], RT[b][2], RT[b][3]);
            timeout = TMO_W'(TMOV[b]);
            for (int e = 1; e <= EDGES[b]; e++) begin
                in_rise();
                // R2 R3 R4 R5 R9
                check("R3 edge sequence", sync_out,
                      exp_vec(RT[b][0], RT[b][1], RT[b][2], RT[b][3], e));
                check("R2 active in burst", active, 1);
                if (e < EDGES[b]) in_low(LOWC[b]);
            end
            // R7: exact timeout cycle, counted from the last edge sample.
            repeat (TMOV[b] - 1) @(posedge clk);
            @(negedge clk);
            check("R7 still active at T-1", active, 1);
            @(posedge clk);
            @(negedge clk);
            check("R7 inactive at T", active, 0);
            // R8
            check("R8 outputs low when idle", sync_out, 0);
            in_low(6);
        end

        // R6: ratio change is taken at the next reload.
        set_ratios(3, 0, 0, 0);
        timeout = TMO_W'(20);
        for (int e = 1; e <= 8; e++) begin
            in_rise();
            check("R6 ratio change", sync_out[0],
                  (e <= 3) ? 1 : (e <= 5) ? 0 : (e <= 7) ? 1 : 0);
            if (e == 2) set_ratios(2, 0, 0, 0);
            in_low(4);
        end
        repeat (25) @(negedge clk);
        check("R7 idle after ratio test", {active, sync_out}, 0);

        // R7 boundary: edges exactly T apart keep the burst alive.
        set_ratios(2, 3, 0, 0);
        timeout = TMO_W'(8);
        for (int e = 1; e <= 6; e++) begin
            in_rise();
            check("R7 gap equal to T keeps active", active, 1);
            check("R4 outputs at T-spaced edges", sync_out, exp_vec(2, 3, 0, 0, e));
            in_low(4);
        end
        repeat (12) @(negedge clk);
        check("R7 expired after boundary burst", active, 0);
        check("R8 outputs cleared", sync_out, 0);

        // R2: new burst realigns from the first edge.
        set_ratios(4, 2, 1, 3);
        timeout = TMO_W'(20);
        in_rise();
        check("R2 realign on new burst", sync_out, exp_vec(4, 2, 1, 3, 1));
        check("R5 ratio one excluded", sync_out[2], 0);

        // R1: reset in the middle of a burst.
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid burst", {active, sync_out}, 0);
        rst_n = 1'b1;
        sig_in = 1'b0;
        repeat (3) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule